// File: doc/BRIEF.md
# Paced Receive Holding Register for a UART-Compatible Host Port

This block is the receive half of a register bank that a host sees as a standard 16550-style UART. A local controller deposits each received byte into a holding register, together with the error status it has gathered for that byte. The host reads the byte at the usual receive-buffer offset. It reads the status at the line-status offset.

A programmable down-counter can pace the hand-over. When pacing is on, each deposit starts a countdown from an 8-bit time constant. The host's data-ready flag and its receive interrupt stay low until the countdown expires. The host therefore never sees bytes arrive faster than a real serial line could deliver them. On the local side, a mirror flag reports at once that the holding register is occupied. That flag stays set until the host has consumed the byte.

Top module: `rx_pace_reg`

## Requirements
- R1: After reset the host data-ready flag, the local mirror flag and the interrupt are 0, all four line-status error bits are 0, and the time constant holds all ones, so a paced deposit with no constant written takes 255 clock edges to release.
- R2: With pacing enabled and a nonzero constant N, a buffer write makes host data-ready rise exactly N clock edges after the edge that takes the write, and not earlier.
- R3: With pacing disabled, host data-ready is set by the same edge that takes the buffer write.
- R4: The local mirror flag is set by the edge that takes a buffer write, whether pacing is on or off.
- R5: With pacing enabled and a constant of 0, a buffer write sets host data-ready on its own edge, the same as with pacing disabled.
- R6: The host interrupt is high exactly when host data-ready is high and the host's receive interrupt enable is 1.
- R7: Each buffer write ORs the shadow error nibble into line-status bits 4..1. Shadow bit 0 maps to overrun (bit 1), bit 1 to parity (bit 2), bit 2 to framing (bit 3) and bit 3 to break (bit 4). The write then clears the shadow, unless a shadow write arrives in the same cycle; that write loads the new value. Line-status bit 0 is data-ready, and bits 7..5 read 0.
- R8: At offset 0 with the divisor-access bit at 0, a host read returns the byte and clears host data-ready, the mirror flag and any pending countdown. With the divisor-access bit at 1, offset 0 reads 0 and clears nothing.
- R9: A host read at offset 5 returns the line status and then clears bits 4..1. Bit 0 is left unchanged. Errors arriving on the same edge are kept.
- R10: A buffer write while the mirror flag is set overwrites the byte, restarts the countdown from the constant and sets the overrun bit.
- R11: A time-constant write takes effect only for later buffer writes. A countdown already running, or one loaded on the same edge, uses the previous value.
- R12: A buffer write and a host buffer read on the same edge are treated as the write arriving just after the read. The new byte is held, the mirror flag is set, no overrun is flagged, and data-ready follows R2, R3 or R5 from a cleared state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| locBufWr | input | 1 | Local write strobe for the holding register |
| locBufData | input | 8 | Byte deposited by the local controller |
| locShadowWr | input | 1 | Local write strobe for the shadow error nibble |
| locShadowErr | input | 4 | Shadow error nibble (overrun, parity, framing, break in bits 0..3) |
| locTcWr | input | 1 | Local write strobe for the time constant |
| locTcData | input | 8 | New time constant |
| timerEn | input | 1 | Pacing enable |
| locDrMirror | output | 1 | Local mirror of the occupied state |
| hostRd | input | 1 | Host read strobe |
| hostAddr | input | 3 | Host register offset |
| hostDlab | input | 1 | Host divisor-access bit |
| hostRxIntEn | input | 1 | Host receive-data interrupt enable |
| hostRdData | output | 8 | Host read data for the addressed register |
| hostDataReady | output | 1 | Host data-ready flag |
| hostIrq | output | 1 | Host receive-data interrupt |

## Verification
The bench builds the block with its default parameters: an 8-bit time constant, a 4-bit error nibble, a 3-bit offset and the buffer and status registers at offsets 0 and 5. With an 8-bit constant, the bench can measure the full 255-edge release from the reset value in a few hundred cycles. It can also measure short constants, a zero constant, a reload in the middle of a countdown, and a constant rewritten during one. A behavioural model predicts the release edge from an edge counter, so every output can be compared on every cycle across the same-edge collisions of read, write and status clear.

// File: rtl/rx_pace_pkg.sv
package rx_pace_pkg;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic loadBuf;     // take a new byte and transfer shadow errors
    logic loadTc;      // take a new time constant
    logic loadShadow;  // take a new shadow error nibble
    logic setOvr;      // flag an overrun on this edge
    logic clrErr;      // line status read: clear error bits
    logic selBuf;      // host address decodes to the buffer
    logic selLsr;      // host address decodes to line status
  } dpStrobe_t;

endpackage

// File: rtl/rx_pace_ctrl.sv
module rx_pace_ctrl
  import rx_pace_pkg::*;
#(
  parameter int TC_W       = 8,
  parameter int ADDR_W     = 3,
  parameter int BUF_OFFSET = 0,
  parameter int LSR_OFFSET = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              locBufWr,
  input  logic              locShadowWr,
  input  logic              locTcWr,
  input  logic              timerEn,
  input  logic              hostRd,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostDlab,
  input  logic [TC_W-1:0]   tcValue,
  output dpStrobe_t         stb,
  output logic              dataReady,
  output logic              mirror
);

  localparam logic [ADDR_W-1:0] BUF_ADDR = ADDR_W'(BUF_OFFSET);
  localparam logic [ADDR_W-1:0] LSR_ADDR = ADDR_W'(LSR_OFFSET);
  localparam logic [TC_W-1:0]   CNT_ONE  = TC_W'(1);

  logic [TC_W-1:0] cnt;
  logic            running;
  logic            selBuf, selLsr, bufRead, lsrRead, immediate;

  assign selBuf    = (hostAddr == BUF_ADDR) && !hostDlab;
  assign selLsr    = (hostAddr == LSR_ADDR);
  assign bufRead   = hostRd && selBuf;
  assign lsrRead   = hostRd && selLsr;
  assign immediate = !timerEn || (tcValue == '0);

  always_comb begin
    stb            = '0;
    stb.loadBuf    = locBufWr;
    stb.loadTc     = locTcWr;
    stb.loadShadow = locShadowWr;
    stb.setOvr     = locBufWr && mirror && !bufRead;
    stb.clrErr     = lsrRead;
    stb.selBuf     = selBuf;
    stb.selLsr     = selLsr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt       <= '0;
      running   <= 1'b0;
      dataReady <= 1'b0;
      mirror    <= 1'b0;
    end else if (locBufWr) begin
      mirror <= 1'b1;
      if (immediate) begin
        dataReady <= 1'b1;
        running   <= 1'b0;
        cnt       <= '0;
      end else begin
        dataReady <= dataReady && !bufRead;
        running   <= 1'b1;
        cnt       <= tcValue;
      end
    end else if (bufRead) begin
      mirror    <= 1'b0;
      dataReady <= 1'b0;
      running   <= 1'b0;
      cnt       <= '0;
    end else if (running) begin
      if (cnt == CNT_ONE) begin
        running   <= 1'b0;
        dataReady <= 1'b1;
        cnt       <= '0;
      end else begin
        cnt <= cnt - CNT_ONE;
      end
    end
  end

  // R4: every deposit marks the register occupied on the local side
  p_mirror_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    locBufWr |=> mirror);

  // R3: unpaced deposit raises data-ready on its own edge
  p_unpaced_ready_r3: assert property (@(posedge clk) disable iff (!rstN)
    locBufWr && !timerEn |=> dataReady);

  // R5: a zero constant releases at once and starts no countdown
  p_zero_tc_r5: assert property (@(posedge clk) disable iff (!rstN)
    locBufWr && timerEn && (tcValue == '0) |=> dataReady && !running);

  // R2: a running countdown never sits at zero
  p_count_live_r2: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (cnt != '0));

  // R2: the last count releases data-ready
  p_release_r2: assert property (@(posedge clk) disable iff (!rstN)
    running && (cnt == CNT_ONE) && !locBufWr && !bufRead |=> dataReady);

  // R2: a paced deposit into an empty register holds data-ready low
  p_no_early_r2: assert property (@(posedge clk) disable iff (!rstN)
    locBufWr && !immediate && !dataReady |=> !dataReady && running);

  // R8: a buffer read empties the register and cancels pacing
  p_read_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    bufRead && !locBufWr |=> !mirror && !dataReady && !running);

endmodule

// File: rtl/rx_pace_dp.sv
module rx_pace_dp
  import rx_pace_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TC_W   = 8,
  parameter int ERR_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [DATA_W-1:0] locBufData,
  input  logic [ERR_W-1:0]  locShadowErr,
  input  logic [TC_W-1:0]   locTcData,
  input  logic              dataReady,
  output logic [TC_W-1:0]   tcValue,
  output logic [DATA_W-1:0] rdData
);

  localparam int PAD_W = DATA_W - ERR_W - 1;
  localparam logic [ERR_W-1:0] OVR_BIT = ERR_W'(1);

  logic [DATA_W-1:0] bufReg;
  logic [TC_W-1:0]   tcReg;
  logic [ERR_W-1:0]  shadow;
  logic [ERR_W-1:0]  errBits;
  logic [ERR_W-1:0]  errNext;
  logic [DATA_W-1:0] lsrView;

  always_comb begin
    errNext = stb.clrErr ? '0 : errBits;
    if (stb.loadBuf) errNext = errNext | shadow;
    if (stb.setOvr)  errNext = errNext | OVR_BIT;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufReg  <= '0;
      tcReg   <= '1;
      shadow  <= '0;
      errBits <= '0;
    end else begin
      errBits <= errNext;
      if (stb.loadBuf) bufReg <= locBufData;
      if (stb.loadTc)  tcReg  <= locTcData;
      if (stb.loadShadow)   shadow <= locShadowErr;
      else if (stb.loadBuf) shadow <= '0;
    end
  end

  assign tcValue = tcReg;
  assign lsrView = {{PAD_W{1'b0}}, errBits, dataReady};
  assign rdData  = stb.selBuf ? bufReg : (stb.selLsr ? lsrView : '0);

  // R10: a deposit over an unread byte leaves overrun set
  p_overrun_r10: assert property (@(posedge clk) disable iff (!rstN)
    stb.setOvr |=> errBits[0]);

  // R9: a status read with no deposit leaves no error standing
  p_lsr_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrErr && !stb.loadBuf |=> (errBits == '0));

  // R7: all shadowed errors appear with the byte
  p_err_xfer_r7: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadBuf |=> ((errBits & $past(shadow)) == $past(shadow)));

  // R11: the constant only moves on its own write strobe
  p_tc_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !stb.loadTc |=> $stable(tcReg));

endmodule

// File: rtl/rx_pace_reg.sv
module rx_pace_reg
  import rx_pace_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int TC_W       = 8,
  parameter int ERR_W      = 4,
  parameter int ADDR_W     = 3,
  parameter int BUF_OFFSET = 0,
  parameter int LSR_OFFSET = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              locBufWr,
  input  logic [DATA_W-1:0] locBufData,
  input  logic              locShadowWr,
  input  logic [ERR_W-1:0]  locShadowErr,
  input  logic              locTcWr,
  input  logic [TC_W-1:0]   locTcData,
  input  logic              timerEn,
  output logic              locDrMirror,
  input  logic              hostRd,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostDlab,
  input  logic              hostRxIntEn,
  output logic [DATA_W-1:0] hostRdData,
  output logic              hostDataReady,
  output logic              hostIrq
);

  dpStrobe_t       stb;
  logic [TC_W-1:0] tcValue;
  logic            dataReady;

  rx_pace_ctrl #(
    .TC_W(TC_W), .ADDR_W(ADDR_W),
    .BUF_OFFSET(BUF_OFFSET), .LSR_OFFSET(LSR_OFFSET)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .locBufWr(locBufWr), .locShadowWr(locShadowWr), .locTcWr(locTcWr),
    .timerEn(timerEn), .hostRd(hostRd), .hostAddr(hostAddr),
    .hostDlab(hostDlab), .tcValue(tcValue),
    .stb(stb), .dataReady(dataReady), .mirror(locDrMirror)
  );

  rx_pace_dp #(
    .DATA_W(DATA_W), .TC_W(TC_W), .ERR_W(ERR_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .locBufData(locBufData), .locShadowErr(locShadowErr),
    .locTcData(locTcData), .dataReady(dataReady),
    .tcValue(tcValue), .rdData(hostRdData)
  );

  assign hostDataReady = dataReady;
  assign hostIrq       = dataReady && hostRxIntEn;

  // R6: the interrupt never runs ahead of data-ready
  p_irq_with_ready_r6: assert property (@(posedge clk) disable iff (!rstN)
    hostIrq |-> hostDataReady);

endmodule

// File: tb/rx_pace_reg_test.sv
module rx_pace_reg_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       locBufWr = 1'b0;
  logic [7:0] locBufData = '0;
  logic       locShadowWr = 1'b0;
  logic [3:0] locShadowErr = '0;
  logic       locTcWr = 1'b0;
  logic [7:0] locTcData = '0;
  logic       timerEn = 1'b0;
  logic       locDrMirror;
  logic       hostRd = 1'b0;
  logic [2:0] hostAddr = '0;
  logic       hostDlab = 1'b0;
  logic       hostRxIntEn = 1'b1;
  logic [7:0] hostRdData;
  logic       hostDataReady;
  logic       hostIrq;

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_pace_reg uut (
    .clk(clk), .rstN(rstN),
    .locBufWr(locBufWr), .locBufData(locBufData),
    .locShadowWr(locShadowWr), .locShadowErr(locShadowErr),
    .locTcWr(locTcWr), .locTcData(locTcData), .timerEn(timerEn),
    .locDrMirror(locDrMirror),
    .hostRd(hostRd), .hostAddr(hostAddr), .hostDlab(hostDlab),
    .hostRxIntEn(hostRxIntEn), .hostRdData(hostRdData),
    .hostDataReady(hostDataReady), .hostIrq(hostIrq)
  );

  task automatic check(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int  cyc = 0;
  int  mTc, mBuf, mShadow, mErr, mRelAt;
  bit  mDr, mMir, mPend;

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (!rstN) begin
      mTc = 255; mBuf = 0; mShadow = 0; mErr = 0; mRelAt = 0;
      mDr = 0; mMir = 0; mPend = 0;
    end else begin
      bit wr, bufRd, lsrRd, imm;
      int nErr;
      wr    = locBufWr;
      bufRd = hostRd && hostAddr == 3'd0 && !hostDlab;
      lsrRd = hostRd && hostAddr == 3'd5;
      imm   = !timerEn || mTc == 0;
      nErr  = lsrRd ? 0 : mErr;
      if (wr) nErr = nErr | mShadow;
      if (wr && mMir && !bufRd) nErr = nErr | 1;
      if (wr) begin
        mMir = 1;
        if (imm) begin mDr = 1; mPend = 0; end
        else begin mDr = mDr && !bufRd; mPend = 1; mRelAt = cyc + mTc; end
        mBuf = locBufData;
      end else if (bufRd) begin
        mMir = 0; mDr = 0; mPend = 0;
      end else if (mPend && cyc == mRelAt) begin
        mDr = 1; mPend = 0;
      end
      mErr = nErr;
      if (locShadowWr) mShadow = locShadowErr;
      else if (wr) mShadow = 0;
      if (locTcWr) mTc = locTcData;
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      int expRd;
      if (hostAddr == 3'd0 && !hostDlab) expRd = mBuf;
      else if (hostAddr == 3'd5) expRd = (mErr << 1) | int'(mDr);
      else expRd = 0;
      check("R2/R3 data-ready", hostDataReady, mDr);
      check("R4 mirror", locDrMirror, mMir);
      check("R6 irq", hostIrq, mDr && hostRxIntEn);
      check("R8/R9 read data", hostRdData, expRd);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic bufWrite(input logic [7:0] d);
    locBufData = d; locBufWr = 1'b1; tick(); locBufWr = 1'b0;
  endtask

  task automatic tcWrite(input logic [7:0] v);
    locTcData = v; locTcWr = 1'b1; tick(); locTcWr = 1'b0;
  endtask

  task automatic shadowWrite(input logic [3:0] v);
    locShadowErr = v; locShadowWr = 1'b1; tick(); locShadowWr = 1'b0;
  endtask

  task automatic hostRead(input logic [2:0] a, output logic [7:0] d);
    hostAddr = a; hostRd = 1'b1; #1 d = hostRdData; tick(); hostRd = 1'b0; hostAddr = 3'd0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    hostAddr = a; #1 d = hostRdData; hostAddr = 3'd0;
  endtask

  task automatic waitReady(output int n);
    n = 0;
    while (!hostDataReady && n < 400) begin tick(); n++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int n;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    tick();

    // R1: reset state, then default constant of 255
    peek(3'd5, d);
    check("R1 line status after reset", d, 8'h00);
    check("R1 data-ready after reset", hostDataReady, 0);
    check("R1 mirror after reset", locDrMirror, 0);
    check("R1 irq after reset", hostIrq, 0);
    timerEn = 1'b1;
    bufWrite(8'h11);
    check("R4 mirror at once when paced", locDrMirror, 1);
    check("R2 no early data-ready", hostDataReady, 0);
    waitReady(n);
    check("R1 default constant release edges", n, 255);
    hostRead(3'd0, d);
    check("R8 buffer byte", d, 8'h11);
    check("R8 read clears data-ready", hostDataReady, 0);
    check("R8 read clears mirror", locDrMirror, 0);

    // R3: unpaced deposit
    timerEn = 1'b0;
    bufWrite(8'h5A);
    check("R3 immediate data-ready", hostDataReady, 1);
    check("R4 mirror unpaced", locDrMirror, 1);
    check("R6 irq with data-ready", hostIrq, 1);
    hostRead(3'd0, d);
    check("R8 buffer byte unpaced", d, 8'h5A);
    check("R6 irq cleared by read", hostIrq, 0);

    // R2: constant of 5
    tcWrite(8'd5);
    timerEn = 1'b1;
    bufWrite(8'hC3);
    check("R2 held low after write", hostDataReady, 0);
    check("R6 irq held back", hostIrq, 0);
    waitReady(n);
    check("R2 release after 5 edges", n, 5);
    check("R6 irq at release", hostIrq, 1);
    hostRead(3'd0, d);

    // R6: interrupt masked
    hostRxIntEn = 1'b0;
    timerEn = 1'b0;
    bufWrite(8'h01);
    check("R6 irq masked", hostIrq, 0);
    check("R3 ready while masked", hostDataReady, 1);
    hostRead(3'd0, d);
    hostRxIntEn = 1'b1;

    // R7 and R9: error transfer and status clear
    shadowWrite(4'b1010);
    bufWrite(8'h77);
    peek(3'd5, d);
    check("R7 errors with byte", d, 8'h15);
    hostRead(3'd5, d);
    check("R9 status read value", d, 8'h15);
    peek(3'd5, d);
    check("R9 errors cleared, ready kept", d, 8'h01);
    hostRead(3'd0, d);
    bufWrite(8'h78);
    peek(3'd5, d);
    check("R7 shadow emptied by transfer", d, 8'h01);
    hostRead(3'd0, d);

    // R10: overrun, unpaced
    bufWrite(8'hA0);
    bufWrite(8'hA1);
    peek(3'd5, d);
    check("R10 overrun flagged", d, 8'h03);
    hostRead(3'd0, d);
    check("R10 newer byte kept", d, 8'hA1);
    hostRead(3'd5, d);

    // R10: reload while counting
    tcWrite(8'd10);
    timerEn = 1'b1;
    bufWrite(8'hB0);
    repeat (4) tick();
    bufWrite(8'hB1);
    waitReady(n);
    check("R10 countdown restarted", n, 10);
    peek(3'd5, d);
    check("R10 overrun on reload", d, 8'h03);
    hostRead(3'd0, d);
    check("R10 reloaded byte", d, 8'hB1);
    hostRead(3'd5, d);

    // R5: zero constant
    tcWrite(8'd0);
    bufWrite(8'hC0);
    check("R5 zero constant immediate", hostDataReady, 1);
    hostRead(3'd0, d);

    // R11: constant rewritten mid-count
    tcWrite(8'd8);
    bufWrite(8'hD0);
    locTcData = 8'd3; locTcWr = 1'b1; tick(); locTcWr = 1'b0;
    waitReady(n);
    check("R11 running count keeps old constant", n + 1, 8);
    hostRead(3'd0, d);
    bufWrite(8'hD1);
    waitReady(n);
    check("R11 new constant on next write", n, 3);
    hostRead(3'd0, d);

    // R12: write and buffer read on one edge
    timerEn = 1'b0;
    bufWrite(8'hE0);
    hostAddr = 3'd0; hostRd = 1'b1;
    locBufData = 8'hE1; locBufWr = 1'b1;
    tick();
    hostRd = 1'b0; locBufWr = 1'b0;
    check("R12 ready after collision", hostDataReady, 1);
    check("R12 mirror after collision", locDrMirror, 1);
    peek(3'd5, d);
    check("R12 no overrun", d, 8'h01);
    peek(3'd0, d);
    check("R12 new byte held", d, 8'hE1);
    hostRead(3'd0, d);

    // R8: divisor-access bit set hides the buffer
    bufWrite(8'hF0);
    hostDlab = 1'b1;
    hostRead(3'd0, d);
    hostDlab = 1'b0;
    check("R8 hidden buffer reads zero", d, 8'h00);
    check("R8 hidden read leaves ready", hostDataReady, 1);
    hostRead(3'd0, d);

    // R8: read cancels a pending release
    timerEn = 1'b1;
    tcWrite(8'd6);
    bufWrite(8'hF1);
    tick();
    hostRead(3'd0, d);
    repeat (12) tick();
    check("R8 read cancels countdown", hostDataReady, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule